// File: doc/BRIEF.md
# Interrupt Moderation Timer Unit

This block collects interrupt causes for a network controller and moderates the rate at which they reach the host. Cause bits are set by one-cycle strobes and held in a cause register. A mask register selects which causes are pending. Reading the cause register returns its contents and clears it.

When causes are pending, no countdown is running and the interrupt line is low, the block computes a delay and arms a countdown. The delay is built from four programmable 16-bit registers and a latched descriptor delay-enable flag, and it is chosen by the kinds of pending cause. The interrupt line rises only when the countdown expires, and only if causes are still pending then. Causes that arrive while the countdown runs only accumulate. A floor on the delay bounds the interrupt rate.

Top module: `irq_moderator`

## Requirements
- R1: Each `cause_set_i` bit ORs into the cause register. `cause_rdata_o` shows the register. A cycle with `cause_rd_i` high leaves only that cycle's `cause_set_i` bits in it.
- R2: A mask set write ORs `mask_wdata_i` into the mask and a mask clear write removes those bits; clear wins when both happen in one cycle. Pending causes are cause AND mask, and masked-off causes never raise `irq_o`.
- R3: A countdown is armed when pending causes exist, no countdown is running and `irq_o` is low. While it runs, no delay is recomputed, and new causes only accumulate.
- R4: The transmit candidate is 4 × the transmit absolute delay register when the delay-enable flag has been seen and cause bit TXDW_BIT (0) or TXQE_BIT (1) is pending; otherwise it is zero.
- R5: The receive candidate is 4 × the receive absolute delay register when the receive delay register is nonzero and cause bit RXT_BIT (7) is pending; otherwise it is zero.
- R6: The throttle register is always a candidate. The delay is the smallest nonzero candidate, or zero when all candidates are zero.
- R7: A delay below DLY_FLOOR (500) is raised to DLY_FLOOR.
- R8: The countdown lasts delay × UNIT_PER_DLY × UNIT_CYC clock cycles. `irq_o` rises only at expiry, and at expiry it takes the value (pending != 0). With inputs registered at edge A, `irq_o` is high after edge A+1+countdown.
- R9: `delay_en_i` sets a flag that is cleared when a countdown is armed.
- R10: Register writes keep only the low 16 bits of `reg_wdata_i`. `reg_sel_i` selects the register: 0 transmit absolute delay, 1 receive delay, 2 receive absolute delay, 3 throttle.
- R11: When no countdown runs, `irq_o` is low in the cycle after the pending set becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_set_i | input | CAUSE_W | Cause set strobes |
| cause_rd_i | input | 1 | Read strobe; clears cause register |
| cause_rdata_o | output | CAUSE_W | Cause register value |
| mask_set_we_i | input | 1 | OR mask_wdata_i into mask |
| mask_clr_we_i | input | 1 | Clear mask_wdata_i bits from mask |
| mask_wdata_i | input | CAUSE_W | Mask write data |
| reg_we_i | input | 1 | Delay register write strobe |
| reg_sel_i | input | 2 | Delay register select |
| reg_wdata_i | input | 32 | Delay register write data |
| delay_en_i | input | 1 | Descriptor delay-enable seen |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle the following: the read-clear behaviour, that an armed delay never falls below the floor or above a sufficient throttle value, that a running countdown decrements and is never reloaded, that the line rises only out of an expiry, that the enable flag clears on arming, and that the line drops when nothing is pending. Only the bench's scenarios can show the exact countdown length for each mix of causes, register values and enable flag, the truncation of written values, and that causes arriving mid-countdown neither restart it nor get lost. The bench also shows that masked causes stay silent until unmasked.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int REG_W = 16;
  localparam int DLY_W = REG_W + 2;

  typedef enum logic [1:0] {
    SEL_TX_ABS   = 2'd0,
    SEL_RX_DLY   = 2'd1,
    SEL_RX_ABS   = 2'd2,
    SEL_THROTTLE = 2'd3
  } dly_sel_e;
endpackage

// File: rtl/imod_cause.sv
module imod_cause #(
  parameter int CAUSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               rd_i,
  input  logic               mask_set_we_i,
  input  logic               mask_clr_we_i,
  input  logic [CAUSE_W-1:0] mask_wdata_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [CAUSE_W-1:0] pending_o
);
  logic [CAUSE_W-1:0] cause_q, mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_set_we_i) mask_d = mask_d | mask_wdata_i;
    if (mask_clr_we_i) mask_d = mask_d & ~mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= rd_i ? set_i : (cause_q | set_i);
      mask_q  <= mask_d;
    end
  end

  assign cause_o   = cause_q;
  assign pending_o = cause_q & mask_q;
endmodule

// File: rtl/imod_regs.sv
module imod_regs
  import irq_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [31:0]      wdata_i,
  output logic [REG_W-1:0] tx_abs_o,
  output logic [REG_W-1:0] rx_dly_o,
  output logic [REG_W-1:0] rx_abs_o,
  output logic [REG_W-1:0] thr_o
);
  localparam int NREG = 4;
  logic [REG_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && sel_i == 2'(g)) regs_q[g] <= wdata_i[REG_W-1:0];
    end
  end

  assign tx_abs_o = regs_q[SEL_TX_ABS];
  assign rx_dly_o = regs_q[SEL_RX_DLY];
  assign rx_abs_o = regs_q[SEL_RX_ABS];
  assign thr_o    = regs_q[SEL_THROTTLE];
endmodule

// File: rtl/imod_delay_calc.sv
module imod_delay_calc
  import irq_mod_pkg::*;
#(
  parameter int CAUSE_W   = 8,
  parameter int TXDW_BIT  = 0,
  parameter int TXQE_BIT  = 1,
  parameter int RXT_BIT   = 7,
  parameter int DLY_FLOOR = 500
) (
  input  logic [CAUSE_W-1:0] pending_i,
  input  logic               ide_i,
  input  logic [REG_W-1:0]   tx_abs_i,
  input  logic [REG_W-1:0]   rx_dly_i,
  input  logic [REG_W-1:0]   rx_abs_i,
  input  logic [REG_W-1:0]   thr_i,
  output logic [DLY_W-1:0]   dly_o
);
  localparam int NCAND = 3;
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(DLY_FLOOR);

  logic [DLY_W-1:0] cand [NCAND];
  logic [DLY_W-1:0] best;

  always_comb begin
    cand[0] = (ide_i && (pending_i[TXDW_BIT] || pending_i[TXQE_BIT]))
              ? {tx_abs_i, 2'b00} : '0;
    cand[1] = (rx_dly_i != '0 && pending_i[RXT_BIT]) ? {rx_abs_i, 2'b00} : '0;
    cand[2] = DLY_W'(thr_i);
    best = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (cand[i] != '0 && (best == '0 || cand[i] < best)) best = cand[i];
    end
    dly_o = (best < FLOOR) ? FLOOR : best;
  end
endmodule

// File: rtl/imod_timer.sv
module imod_timer #(
  parameter int DLY_W = 18,
  parameter int TICK  = 256,
  localparam int CNT_W = DLY_W + $clog2(TICK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             run_o,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (arm_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(dly_i) * CNT_W'(TICK) - 1'b1;
    end
  end

  assign run_o    = run_q;
  assign expire_o = run_q && cnt_q == '0;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int CAUSE_W      = 8,
  parameter int TXDW_BIT     = 0,
  parameter int TXQE_BIT     = 1,
  parameter int RXT_BIT      = 7,
  parameter int DLY_FLOOR    = 500,
  parameter int UNIT_PER_DLY = 256,
  parameter int UNIT_CYC     = 1,
  localparam int TICK        = UNIT_PER_DLY * UNIT_CYC,
  localparam int CNT_W       = DLY_W + $clog2(TICK + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] cause_set_i,
  input  logic               cause_rd_i,
  output logic [CAUSE_W-1:0] cause_rdata_o,
  input  logic               mask_set_we_i,
  input  logic               mask_clr_we_i,
  input  logic [CAUSE_W-1:0] mask_wdata_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               delay_en_i,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] pending;
  logic [REG_W-1:0]   tx_abs, rx_dly, rx_abs, thr;
  logic [DLY_W-1:0]   calc_dly;
  logic [CNT_W-1:0]   tmr_cnt;
  logic               tmr_run, tmr_expire, arm, ide_q, ide_seen, irq_q;

  imod_cause #(.CAUSE_W(CAUSE_W)) i_cause (
    .clk_i, .rst_ni,
    .set_i(cause_set_i), .rd_i(cause_rd_i),
    .mask_set_we_i, .mask_clr_we_i, .mask_wdata_i,
    .cause_o(cause_rdata_o), .pending_o(pending)
  );

  imod_regs i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .tx_abs_o(tx_abs), .rx_dly_o(rx_dly), .rx_abs_o(rx_abs), .thr_o(thr)
  );

  assign ide_seen = ide_q | delay_en_i;

  imod_delay_calc #(
    .CAUSE_W(CAUSE_W), .TXDW_BIT(TXDW_BIT), .TXQE_BIT(TXQE_BIT),
    .RXT_BIT(RXT_BIT), .DLY_FLOOR(DLY_FLOOR)
  ) i_calc (
    .pending_i(pending), .ide_i(ide_seen),
    .tx_abs_i(tx_abs), .rx_dly_i(rx_dly), .rx_abs_i(rx_abs), .thr_i(thr),
    .dly_o(calc_dly)
  );

  // arm only while the line is low: moderates each rising edge
  assign arm = !tmr_run && !irq_q && (pending != '0);

  imod_timer #(.DLY_W(DLY_W), .TICK(TICK)) i_timer (
    .clk_i, .rst_ni,
    .arm_i(arm), .dly_i(calc_dly),
    .run_o(tmr_run), .expire_o(tmr_expire), .cnt_o(tmr_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ide_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ide_q <= arm ? 1'b0 : ide_seen;
      if (tmr_expire)            irq_q <= (pending != '0);
      else if (!tmr_run && pending == '0) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int CAUSE_W   = 8,
  parameter int DLY_W     = 18,
  parameter int CNT_W     = 27,
  parameter int REG_W     = 16,
  parameter int DLY_FLOOR = 500
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CAUSE_W-1:0] cause_set_i,
  input logic               cause_rd_i,
  input logic [CAUSE_W-1:0] cause_rdata_o,
  input logic [CAUSE_W-1:0] pending,
  input logic               irq_o,
  input logic               arm,
  input logic [DLY_W-1:0]   calc_dly,
  input logic [REG_W-1:0]   thr,
  input logic               tmr_run,
  input logic               tmr_expire,
  input logic [CNT_W-1:0]   tmr_cnt,
  input logic               ide_q
);
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(DLY_FLOOR);

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_rd_i |=> cause_rdata_o == $past(cause_set_i)); // R1

  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> pending != '0); // R2

  AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_run && !tmr_expire) |=> (tmr_run && tmr_cnt == $past(tmr_cnt) - 1'b1)); // R3

  AST_THROTTLE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && DLY_W'(thr) >= FLOOR) |-> calc_dly <= DLY_W'(thr)); // R6

  AST_FLOOR_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |-> calc_dly >= FLOOR); // R7

  AST_RISE_AT_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tmr_expire)); // R8

  AST_IDE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> !ide_q); // R9

  AST_FALL_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_run && pending == '0) |=> !irq_o); // R11
endmodule

bind irq_moderator irq_moderator_chk #(
  .CAUSE_W(CAUSE_W), .DLY_W(irq_mod_pkg::DLY_W), .CNT_W(CNT_W),
  .REG_W(irq_mod_pkg::REG_W), .DLY_FLOOR(DLY_FLOOR)
) i_chk (
  .clk_i, .rst_ni, .cause_set_i, .cause_rd_i, .cause_rdata_o,
  .pending, .irq_o, .arm, .calc_dly, .thr, .tmr_run, .tmr_expire,
  .tmr_cnt, .ide_q
);

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
  localparam int FLOOR = 500;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cause_set_i = '0;
  logic       cause_rd_i = 1'b0;
  logic [7:0] cause_rdata_o;
  logic       mask_set_we_i = 1'b0, mask_clr_we_i = 1'b0;
  logic [7:0] mask_wdata_i = '0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic       delay_en_i = 1'b0;
  logic       irq_o;

  int checks = 0, errors = 0, cyc = 0;
  int m_tx = 0, m_rxd = 0, m_rxa = 0, m_thr = 0;

  always #2.5 clk_i = ~clk_i;

  irq_moderator #(.UNIT_PER_DLY(1), .UNIT_CYC(1)) i_irq_moderator (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_delay(input int thr, tx, rxd, rxa, input bit ide,
                                   input logic [7:0] pend);
    int c[3];
    int best = 0;
    c[0] = (ide && (pend[0] || pend[1])) ? tx * 4 : 0;
    c[1] = (rxd != 0 && pend[7]) ? rxa * 4 : 0;
    c[2] = thr;
    foreach (c[i]) if (c[i] != 0 && (best == 0 || c[i] < best)) best = c[i];
    return (best < FLOOR) ? FLOOR : best;
  endfunction

  task automatic wr_reg(input int sel, input logic [31:0] val);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = 2'(sel); reg_wdata_i = val;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (sel)
      0: m_tx  = int'(val & 32'hFFFF);
      1: m_rxd = int'(val & 32'hFFFF);
      2: m_rxa = int'(val & 32'hFFFF);
      default: m_thr = int'(val & 32'hFFFF);
    endcase
  endtask

  task automatic set_regs(input int tx, rxd, rxa, thr);
    wr_reg(0, 32'(tx)); wr_reg(1, 32'(rxd)); wr_reg(2, 32'(rxa)); wr_reg(3, 32'(thr));
  endtask

  task automatic mask_wr(input bit set, input logic [7:0] v);
    @(negedge clk_i);
    mask_set_we_i = set; mask_clr_we_i = !set; mask_wdata_i = v;
    @(negedge clk_i);
    mask_set_we_i = 1'b0; mask_clr_we_i = 1'b0;
  endtask

  // pulse causes, optional late causes at count late_at; k = N+2 on correct design
  task automatic run_irq(input logic [7:0] bits, input bit ide,
                         input logic [7:0] late, input int late_at, output int k);
    @(negedge clk_i);
    cause_set_i = bits; delay_en_i = ide;
    @(posedge clk_i);
    @(negedge clk_i);
    cause_set_i = '0; delay_en_i = 1'b0;
    k = 1;
    while (!irq_o && k < 20000) begin
      if (k == late_at) cause_set_i = late;
      @(posedge clk_i);
      k++;
      @(negedge clk_i);
      cause_set_i = '0;
    end
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    cause_rd_i = 1'b1;
    @(negedge clk_i);
    cause_rd_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    int k, e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R8 reset irq", int'(irq_o), 0);
    chk(cause_rdata_o == 8'h00, "R1 reset cause", int'(cause_rdata_o), 0);
    mask_wr(1'b1, 8'hFF);

    // R6 throttle alone
    set_regs(0, 0, 0, 700);
    run_irq(8'h04, 1'b0, 8'h00, 0, k);
    chk(k == 702, "R6 throttle only", k, 702);
    chk(cause_rdata_o == 8'h04, "R1 cause readback", int'(cause_rdata_o), 4);
    clear_all();
    chk(irq_o == 1'b0, "R11 irq drops after read clear", int'(irq_o), 0);
    chk(cause_rdata_o == 8'h00, "R1 cleared by read", int'(cause_rdata_o), 0);

    // R7 floor
    wr_reg(3, 100);
    run_irq(8'h04, 1'b0, 8'h00, 0, k);
    chk(k == FLOOR + 2, "R7 floor on small throttle", k, FLOOR + 2);
    clear_all();
    wr_reg(3, 0);
    run_irq(8'h04, 1'b0, 8'h00, 0, k);
    chk(k == FLOOR + 2, "R6 all candidates zero", k, FLOOR + 2);
    clear_all();

    // R4 transmit candidate with delay enable, then R9 flag gone
    set_regs(200, 0, 0, 2000);
    run_irq(8'h01, 1'b1, 8'h00, 0, k);
    chk(k == 802, "R4 tx absolute delay", k, 802);
    clear_all();
    run_irq(8'h02, 1'b0, 8'h00, 0, k);
    chk(k == 2002, "R9 enable flag cleared on arm", k, 2002);
    clear_all();

    // R5 receive candidate gated by receive delay
    set_regs(0, 0, 150, 2000);
    run_irq(8'h80, 1'b0, 8'h00, 0, k);
    chk(k == 2002, "R5 rx delay zero ignores rx abs", k, 2002);
    clear_all();
    wr_reg(1, 5);
    run_irq(8'h80, 1'b0, 8'h00, 0, k);
    chk(k == 602, "R5 rx absolute delay", k, 602);
    clear_all();

    // R10 upper bits dropped
    set_regs(0, 0, 0, 0);
    wr_reg(3, 32'h0001_02BC);
    run_irq(8'h04, 1'b0, 8'h00, 0, k);
    chk(k == 702, "R10 low 16 bits kept", k, 702);
    clear_all();

    // R3 causes accumulate during countdown, no restart
    wr_reg(3, 600);
    run_irq(8'h04, 1'b0, 8'h08, 50, k);
    chk(k == 602, "R3 no restart on late cause", k, 602);
    chk(cause_rdata_o == 8'h0C, "R3 late cause kept", int'(cause_rdata_o), 12);
    clear_all();

    // R2 masked cause stays silent until unmasked
    mask_wr(1'b0, 8'h10);
    @(negedge clk_i); cause_set_i = 8'h10;
    @(negedge clk_i); cause_set_i = '0;
    repeat (FLOOR + 700) @(negedge clk_i);
    chk(irq_o == 1'b0, "R2 masked cause no irq", int'(irq_o), 0);
    chk(cause_rdata_o == 8'h10, "R2 masked cause recorded", int'(cause_rdata_o), 16);
    @(negedge clk_i);
    mask_set_we_i = 1'b1; mask_wdata_i = 8'h10;
    @(posedge clk_i);
    @(negedge clk_i);
    mask_set_we_i = 1'b0;
    k = 1;
    while (!irq_o && k < 20000) begin @(posedge clk_i); k++; @(negedge clk_i); end
    chk(k == 602, "R2 unmask arms countdown", k, 602);
    // R2 set and clear same cycle: clear wins
    @(negedge clk_i);
    mask_set_we_i = 1'b1; mask_clr_we_i = 1'b1; mask_wdata_i = 8'hFF;
    @(negedge clk_i);
    mask_set_we_i = 1'b0; mask_clr_we_i = 1'b0;
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R2 clear wins, nothing pending", int'(irq_o), 0);
    mask_wr(1'b1, 8'hFF);
    // R1 set during read survives
    @(negedge clk_i); cause_rd_i = 1'b1; cause_set_i = 8'h20;
    @(negedge clk_i); cause_rd_i = 1'b0; cause_set_i = '0;
    chk(cause_rdata_o == 8'h20, "R1 set beats read clear", int'(cause_rdata_o), 32);
    repeat (605) @(negedge clk_i);
    clear_all();

    // R8 random mixes
    for (int it = 0; it < 16; it++) begin
      logic [7:0] b;
      bit ide;
      set_regs($urandom_range(0, 400), $urandom_range(0, 3),
               $urandom_range(0, 400), $urandom_range(0, 1400));
      b = 8'($urandom) & 8'h8B;
      if (b == 8'h00) b = 8'h08;
      ide = 1'($urandom);
      e = exp_delay(m_thr, m_tx, m_rxd, m_rxa, ide, b);
      run_irq(b, ide, 8'h00, 0, k);
      chk(k == e + 2, "R8 random countdown length", k, e + 2);
      clear_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule